// File: doc/BRIEF.md
# Oversampling asynchronous serial receiver

This block receives asynchronous serial frames on a single line and hands each byte to the host through a one-entry holding register. A built-in rate divider makes a sampling tick at sixteen times the bit rate. The divisor comes from a rate word, and a fast-mode bit selects whether an extra divide by four is applied. Each frame starts with a low start bit, carries 8 or 9 data bits least significant first, and ends with a high stop bit.

The start of a frame is found on a high-to-low change of the sampled line. It is confirmed only if the line stays low for three sample ticks in a row. Every data bit and the stop bit are resolved by a 2-of-3 vote taken at mid-bit. Received words wait in the holding register until the host reads them. The block keeps sticky framing and overrun flags. For multidrop buses, an address-filter mode passes only 9-bit frames whose top bit is set.

Top module: `uart_os_rx`

## Requirements
- R1: The divider emits one sample tick every (rate_i+1) clocks when fast_i=1, and every 4*(rate_i+1) clocks when fast_i=0. One bit time is 16 sample ticks.
- R2: A start bit is accepted only after three consecutive low samples that follow a high sample. A low pulse shorter than that is ignored, and no word is produced from it.
- R3: Each data bit and the stop bit take the majority of three samples at ticks 7, 8 and 9 of the bit. A wrong value on one sample does not change the received bit.
- R4: With nine_bit_i=0 a frame carries 8 data bits LSB first and bit9_o reads 0. With nine_bit_i=1 a ninth bit follows and appears on bit9_o.
- R5: A stop bit resolved as 0 sets frame_err_o. The word is still delivered. The flag stays set until clr_err_i is pulsed.
- R6: A delivered word loads data_o/bit9_o and sets ready_o. A one-cycle rd_i pulse clears ready_o.
- R7: If a word completes while ready_o is still set, overrun_o is set and the holding register keeps the earlier word. While overrun_o is set, further words are discarded. Only clr_err_i clears the flag; rd_i does not.
- R8: With addr_det_i=1 and nine_bit_i=1, a frame whose ninth bit is 0 is discarded: ready_o, the data outputs and the flags do not change. A frame whose ninth bit is 1 is delivered.
- R9: Holding rx_en_i low returns the frame logic to idle. A frame interrupted this way produces no word, and the next full frame is received correctly.
- R10: After reset, ready_o, frame_err_o, overrun_o, bit9_o and data_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; low forces the frame logic idle |
| rx_i | input | 1 | Serial line, idle high |
| rate_i | input | RATE_W | Divider compare value |
| fast_i | input | 1 | 1: tick every rate_i+1 clocks; 0: four times slower |
| nine_bit_i | input | 1 | Selects 9 data bits per frame |
| addr_det_i | input | 1 | Address filter enable (9-bit mode) |
| rd_i | input | 1 | Read strobe, clears ready_o |
| clr_err_i | input | 1 | Clears frame_err_o and overrun_o |
| data_o | output | DATA_W | Held data bits |
| bit9_o | output | 1 | Held ninth bit |
| ready_o | output | 1 | Holding register has an unread word |
| frame_err_o | output | 1 | Sticky framing error |
| overrun_o | output | 1 | Sticky overrun error |

## Verification
The bench drives a two-tick low glitch. A receiver that starts on a single low sample would turn this glitch into a spurious 0xFF-like word, and the scoreboard would see it out of order. It flips one sample at the centre of a bit. A receiver that takes a single sample instead of voting would return a corrupted byte. It also sends a filtered address frame, a frame with a low stop bit, three frames without reads, and a frame cut short by dropping enable. A wrong design would deliver the filtered frame, clear the framing flag early, let a later byte overwrite the held one, or resume the interrupted frame and shift garbage into the next word.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  localparam int unsigned OVS      = 16;
  localparam int unsigned PH_W     = $clog2(OVS);
  localparam int unsigned SLOW_DIV = 4;
  localparam logic [PH_W-1:0] PH_QUAL = PH_W'(3);
  localparam logic [PH_W-1:0] PH_V0   = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0] PH_V1   = PH_W'(OVS/2);
  localparam logic [PH_W-1:0] PH_V2   = PH_W'(OVS/2 + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;
endpackage

// File: rtl/uart_os_baud.sv
module uart_os_baud
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              fast_i,
  output logic              tick_o
);
  localparam int unsigned PRE_W = $clog2(SLOW_DIV);

  logic [RATE_W-1:0] cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic              base;

  assign base   = en_i && (cnt_q >= rate_i);
  assign tick_o = base && (fast_i || pre_q == PRE_W'(SLOW_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      cnt_q <= base ? '0 : cnt_q + 1'b1;
      if (base) pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_os_frame.sv
module uart_os_frame
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned FRAME_W = DATA_W + 1,
  localparam int unsigned IDX_W   = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               rx_i,
  input  logic               nine_bit_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] word_o,
  output logic               stop_ok_o,
  output logic               busy_o
);
  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic [PH_W-1:0]   phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        ones_q;
  logic              prev_hi_q;
  logic              rx_s;
  logic              vote;
  logic [IDX_W-1:0]  last_idx;

  assign rx_s     = sync_q[1];
  assign vote     = (ones_q + {1'b0, rx_s}) >= 2'd2;
  assign last_idx = nine_bit_i ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign busy_o   = state_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 2'b11;
      state_q   <= ST_IDLE;
      phase_q   <= '0;
      idx_q     <= '0;
      ones_q    <= '0;
      prev_hi_q <= 1'b0;
      word_o    <= '0;
      done_o    <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      done_o <= 1'b0;
      if (!en_i) begin
        state_q   <= ST_IDLE;
        prev_hi_q <= 1'b0;
      end else if (tick_i) begin
        prev_hi_q <= rx_s;
        phase_q   <= phase_q + 1'b1;
        if (phase_q == PH_V0)      ones_q <= {1'b0, rx_s};
        else if (phase_q == PH_V1) ones_q <= ones_q + {1'b0, rx_s};
        unique case (state_q)
          ST_IDLE: begin
            phase_q <= PH_W'(1);
            if (!rx_s && prev_hi_q) begin
              state_q <= ST_START;
              idx_q   <= '0;
              word_o  <= '0;
            end
          end
          ST_START: begin
            // three low samples in a row qualify the start edge
            if (phase_q < PH_QUAL && rx_s)  state_q <= ST_IDLE;
            else if (phase_q == PH_LAST)    state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (phase_q == PH_V2) word_o[idx_q] <= vote;
            if (phase_q == PH_LAST) begin
              if (idx_q == last_idx) state_q <= ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (phase_q == PH_V2) begin
              done_o    <= 1'b1;
              stop_ok_o <= vote;
              state_q   <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_os_hold.sv
module uart_os_hold #(
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned FRAME_W = DATA_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               stop_ok_i,
  input  logic               nine_bit_i,
  input  logic               addr_det_i,
  input  logic               rd_i,
  input  logic               clr_err_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               ready_o,
  output logic               frame_err_o,
  output logic               overrun_o
);
  logic drop_addr, accept, free, load;

  assign drop_addr = addr_det_i && nine_bit_i && !word_i[FRAME_W-1];
  assign accept    = done_i && !drop_addr;
  assign free      = !ready_o || rd_i;
  assign load      = accept && !overrun_o && free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o      <= '0;
      ready_o     <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      if (load) word_o <= word_i;

      if (load)      ready_o <= 1'b1;
      else if (rd_i) ready_o <= 1'b0;

      if (accept && !stop_ok_i) frame_err_o <= 1'b1;
      else if (clr_err_i)       frame_err_o <= 1'b0;

      if (accept && !overrun_o && !free) overrun_o <= 1'b1;
      else if (clr_err_i)                overrun_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned RATE_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              rx_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              fast_i,
  input  logic              nine_bit_i,
  input  logic              addr_det_i,
  input  logic              rd_i,
  input  logic              clr_err_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              ready_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  localparam int unsigned FRAME_W = DATA_W + 1;

  logic               tick;
  logic               frm_done;
  logic               frm_stop_ok;
  logic               frm_busy;
  logic [FRAME_W-1:0] frm_word;
  logic [FRAME_W-1:0] held_word;

  uart_os_baud #(.RATE_W(RATE_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_i),
    .rate_i (rate_i),
    .fast_i (fast_i),
    .tick_o (tick)
  );

  uart_os_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rx_en_i),
    .tick_i     (tick),
    .rx_i       (rx_i),
    .nine_bit_i (nine_bit_i),
    .done_o     (frm_done),
    .word_o     (frm_word),
    .stop_ok_o  (frm_stop_ok),
    .busy_o     (frm_busy)
  );

  uart_os_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (frm_done),
    .word_i      (frm_word),
    .stop_ok_i   (frm_stop_ok),
    .nine_bit_i  (nine_bit_i),
    .addr_det_i  (addr_det_i),
    .rd_i        (rd_i),
    .clr_err_i   (clr_err_i),
    .word_o      (held_word),
    .ready_o     (ready_o),
    .frame_err_o (frame_err_o),
    .overrun_o   (overrun_o)
  );

  assign data_o = held_word[DATA_W-1:0];
  assign bit9_o = held_word[DATA_W];
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              nine_bit_i,
  input logic              addr_det_i,
  input logic              rd_i,
  input logic              clr_err_i,
  input logic [DATA_W-1:0] data_o,
  input logic              ready_o,
  input logic              frame_err_o,
  input logic              overrun_o,
  input logic              frm_done,
  input logic [DATA_W:0]   frm_word,
  input logic              frm_busy
);
  a_r5_frame_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o && !clr_err_i |=> frame_err_o);

  a_r7_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !clr_err_i |=> overrun_o);

  a_r7_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> $stable(data_o));

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !frm_done |=> !ready_o);

  a_r6_ready_from_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && !frm_done |=> !ready_o);

  a_r8_addr_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_det_i && nine_bit_i && frm_done && !frm_word[DATA_W] && !rd_i
    |=> ready_o == $past(ready_o) && $stable(data_o));

  a_r9_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !frm_busy);
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .nine_bit_i  (nine_bit_i),
  .addr_det_i  (addr_det_i),
  .rd_i        (rd_i),
  .clr_err_i   (clr_err_i),
  .data_o      (data_o),
  .ready_o     (ready_o),
  .frame_err_o (frame_err_o),
  .overrun_o   (overrun_o),
  .frm_done    (frm_done),
  .frm_word    (frm_word),
  .frm_busy    (frm_busy)
);

// File: tb/uart_os_rx_test.sv
module uart_os_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int RATE_W = 8;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rx_en_i = 1'b0;
  logic              rx_i = 1'b1;
  logic [RATE_W-1:0] rate_i = 8'd3;
  logic              fast_i = 1'b1;
  logic              nine_bit_i = 1'b0;
  logic              addr_det_i = 1'b0;
  logic              rd_i = 1'b0;
  logic              clr_err_i = 1'b0;
  logic [DATA_W-1:0] data_o;
  logic              bit9_o, ready_o, frame_err_o, overrun_o;

  int total = 0;
  int bad = 0;
  int tk = 4;
  bit auto_rd = 1'b0;
  bit finished = 1'b0;
  logic [8:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_os_rx #(.RATE_W(RATE_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .rx_i(rx_i),
    .rate_i(rate_i), .fast_i(fast_i), .nine_bit_i(nine_bit_i),
    .addr_det_i(addr_det_i), .rd_i(rd_i), .clr_err_i(clr_err_i),
    .data_o(data_o), .bit9_o(bit9_o), .ready_o(ready_o),
    .frame_err_o(frame_err_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic v, input bit glitch);
    rx_i = v;
    if (glitch) begin
      wait_clk(8 * tk);
      rx_i = ~v;
      wait_clk(tk);
      rx_i = v;
      wait_clk(7 * tk);
    end else begin
      wait_clk(16 * tk);
    end
  endtask

  // R4: start bit, data LSB first (8 or 9 bits), stop bit
  task automatic send(input logic [8:0] w, input logic stop, input int gbit);
    int nb;
    nb = nine_bit_i ? 9 : 8;
    put_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) put_bit(w[i], gbit == i);
    put_bit(stop, 1'b0);
    rx_i = 1'b1;
    wait_clk(16 * tk);
  endtask

  task automatic send_exp(input logic [8:0] w);
    expq.push_back(nine_bit_i ? w : {1'b0, w[7:0]});
    send(w, 1'b1, -1);
  endtask

  task automatic pulse_clr();
    clr_err_i = 1'b1;
    wait_clk(1);
    clr_err_i = 1'b0;
    wait_clk(1);
  endtask

  // scoreboard monitor: pops expected words as the design presents them
  initial begin
    forever begin
      @(negedge clk);
      if (auto_rd) begin
        if (ready_o && !rd_i) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R6 unexpected word", {bit9_o, data_o}, 0);
          end else begin
            logic [8:0] e;
            e = expq.pop_front();
            chk({bit9_o, data_o} == e, "R4 R6 received word", {bit9_o, data_o}, e);
          end
          rd_i = 1'b1;
        end else begin
          rd_i = 1'b0;
        end
      end
    end
  end

  initial begin
    wait_clk(150000);
    chk(1'b0, "watchdog", 0, 1);
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    // R10 reset state
    chk(ready_o == 1'b0, "R10 ready", ready_o, 0);
    chk({frame_err_o, overrun_o} == 2'b00, "R10 flags", {frame_err_o, overrun_o}, 0);
    chk({bit9_o, data_o} == 9'h0, "R10 data", {bit9_o, data_o}, 0);
    rst_ni = 1'b1;
    wait_clk(2);
    rx_en_i = 1'b1;
    auto_rd = 1'b1;
    wait_clk(32 * tk);

    // R1 fast mode, tick every rate+1 = 4 clocks
    tk = 4;
    send_exp(9'h0A5);
    send_exp(9'h03C);
    send_exp(9'h000);
    send_exp(9'h0FF);
    chk(expq.size() == 0, "R1 fast words delivered", expq.size(), 0);
    chk(ready_o == 1'b0, "R6 read clears ready", ready_o, 0);

    // R1 slow mode, tick every 4*(rate+1) = 8 clocks
    fast_i = 1'b0; rate_i = 8'd1; tk = 8;
    wait_clk(32 * tk);
    send_exp(9'h05A);
    send_exp(9'h081);
    chk(expq.size() == 0, "R1 slow words delivered", expq.size(), 0);
    fast_i = 1'b1; rate_i = 8'd3; tk = 4;
    wait_clk(32 * tk);

    // R2 two-tick low glitch is ignored
    rx_i = 1'b0;
    wait_clk(2 * tk);
    rx_i = 1'b1;
    wait_clk(220 * tk);
    chk(ready_o == 1'b0 && expq.size() == 0, "R2 glitch ignored", ready_o, 0);
    send_exp(9'h096);
    chk(expq.size() == 0, "R2 frame after glitch", expq.size(), 0);

    // R3 single flipped sample at bit centre
    send_exp(9'h000); expq.delete(expq.size() - 1);
    expq.push_back(9'h000); send(9'h000, 1'b1, 3);
    expq.push_back(9'h0FF); send(9'h0FF, 1'b1, 6);
    chk(expq.size() == 0, "R3 vote words delivered", expq.size(), 0);

    // R4 nine-bit frames
    nine_bit_i = 1'b1;
    send_exp(9'h1AB);
    send_exp(9'h055);
    chk(expq.size() == 0, "R4 nine-bit delivered", expq.size(), 0);

    // R8 address filter
    addr_det_i = 1'b1;
    send(9'h022, 1'b1, -1);
    chk(ready_o == 1'b0, "R8 data frame discarded", ready_o, 0);
    send_exp(9'h133);
    chk(expq.size() == 0, "R8 address frame delivered", expq.size(), 0);
    addr_det_i = 1'b0;
    nine_bit_i = 1'b0;

    // R5 framing error, sticky
    expq.push_back(9'h047);
    send(9'h047, 1'b0, -1);
    chk(frame_err_o == 1'b1, "R5 framing set", frame_err_o, 1);
    send_exp(9'h011);
    chk(frame_err_o == 1'b1, "R5 framing sticky", frame_err_o, 1);
    pulse_clr();
    chk(frame_err_o == 1'b0, "R5 framing cleared", frame_err_o, 0);

    // R7 overrun
    auto_rd = 1'b0;
    wait_clk(2);
    rd_i = 1'b0;
    send(9'h061, 1'b1, -1);
    send(9'h062, 1'b1, -1);
    send(9'h063, 1'b1, -1);
    chk(overrun_o == 1'b1, "R7 overrun set", overrun_o, 1);
    chk(ready_o == 1'b1 && data_o == 8'h61, "R7 first word kept", data_o, 8'h61);
    rd_i = 1'b1; wait_clk(1); rd_i = 1'b0; wait_clk(1);
    chk(ready_o == 1'b0, "R6 manual read", ready_o, 0);
    chk(overrun_o == 1'b1, "R7 read leaves overrun", overrun_o, 1);
    send(9'h064, 1'b1, -1);
    chk(ready_o == 1'b0 && data_o == 8'h61, "R7 dropped while overrun", data_o, 8'h61);
    pulse_clr();
    chk(overrun_o == 1'b0, "R7 overrun cleared", overrun_o, 0);
    auto_rd = 1'b1;
    send_exp(9'h065);
    chk(expq.size() == 0, "R7 reception resumes", expq.size(), 0);

    // R9 enable low aborts a frame
    put_bit(1'b0, 1'b0);
    put_bit(1'b0, 1'b0);
    put_bit(1'b0, 1'b0);
    rx_en_i = 1'b0;
    wait_clk(4);
    rx_i = 1'b1;
    rx_en_i = 1'b1;
    wait_clk(200 * tk);
    chk(ready_o == 1'b0, "R9 aborted frame dropped", ready_o, 0);
    send_exp(9'h0C3);
    chk(expq.size() == 0, "R9 next frame correct", expq.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule